// File: doc/BRIEF.md
# Read-Window Margin Scanner

This controller measures how wide the read capture window of a memory interface is, one bit lane at a time. Once started, it takes sole control of a fine phase-delay tap adjuster. It watches a sticky error flag raised by an external traffic checker. For each lane it first moves the delay upward one tap at a time until the checker reports an error. It then walks back to the calibrated tap and clears the error. Next it moves the delay downward the same way, walks back again and clears the error once more. The number of taps taken before each error is the margin on that side of the window.

A short settle interval follows every tap move and every error clear, so that the checker's traffic sees the new delay before the flag is sampled. When the scanner is idle, manual increment and decrement requests pass straight through to the tap port. While a scan runs, those requests are dropped. The delay line reports its current tap for the selected lane on `tap_pos`. The scanner uses it only to detect the ends of the tap range.

Top module: `rws_scanner`

## Requirements
- R1: A one-cycle `start` while idle begins a scan. `busy` is high in that same cycle and stays high through the cycle in which the last lane's result is written. It is low in the cycle after that.
- R2: While `busy` is high, `man_inc` and `man_dec` have no effect on `tap_inc`/`tap_dec`. While idle, `tap_inc` follows `man_inc` and `tap_dec` follows `man_dec` in the same cycle.
- R3: The right sweep pulses `tap_inc` once per step until `err_in` is found high at a sample point. The right margin is the number of increments taken before that sample.
- R4: After each sweep, the scanner pulses the opposite strobe until the tap is back at its starting point, then gives a one-cycle `err_clr`. No two of `tap_inc`, `tap_dec` and `err_clr` are high in the same cycle while busy.
- R5: The left sweep pulses `tap_dec` once per step until `err_in` is found high. The left margin is the number of decrements taken.
- R6: Lanes are scanned in ascending order from 0 to NUM_LANES-1. `lane_sel` names the lane under test, and each lane yields exactly one result write.
- R7: If the left sweep reaches tap 0 with no error, the left margin is the number of decrements taken (the starting tap) and `res_left_unb` is set. Otherwise that flag is clear.
- R8: If the right sweep reaches tap 63 (the top of a 6-bit range) with no error, the right margin is 63 minus the starting tap and `res_right_sat` is set. An error seen at the same sample as tap 63 counts as a real edge, so the flag stays clear.
- R9: Between any scanner tap strobe and the preceding strobe or error clear there are at least `settle_cycles` cycles.
- R10: At the end of each lane the tap is back at the value it held before that lane's scan began.
- R11: `res_we` is a one-cycle strobe per lane. It carries `res_lane`, 8-bit `res_left` and `res_right`, and the two flags.
- R12: A synchronous `rst` aborts any scan. In the cycle after reset, `busy`, `err_clr`, `res_we` and the tap strobes are low unless a new `start` or an idle manual request drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle scan request |
| settle_cycles | input | SETTLE_W | Wait after each tap move or error clear |
| man_inc | input | 1 | Manual tap increment request |
| man_dec | input | 1 | Manual tap decrement request |
| tap_pos | input | TAP_W | Current tap of the selected lane |
| err_in | input | 1 | Sticky error from the traffic checker |
| busy | output | 1 | Scan in progress |
| tap_inc | output | 1 | Tap increment strobe to the delay line |
| tap_dec | output | 1 | Tap decrement strobe to the delay line |
| err_clr | output | 1 | Clear strobe for the sticky error |
| lane_sel | output | LANE_W | Lane under test |
| res_we | output | 1 | Result write strobe |
| res_lane | output | LANE_W | Lane of the written result |
| res_left | output | MARGIN_W | Left margin in taps |
| res_right | output | MARGIN_W | Right margin in taps |
| res_left_unb | output | 1 | Left sweep hit tap 0 without error |
| res_right_sat | output | 1 | Right sweep hit top tap without error |

## Verification
The bound checker enforces several rules on every cycle: at most one of increment, decrement and error clear per cycle, the minimum settle gap between scanner strobes, single-cycle result writes in ascending lane order, `busy` falling after the last write, and a quiet cycle after reset. Margin values, the two limit flags and the restoration of each lane's tap can only be shown by the bench. Its delay-line and checker model is given windows that are bounded on both sides, clipped at tap 0, clipped at tap 63, and exactly at tap 63. The bench also covers manual requests that are dropped during a scan, pass-through while idle, and a reset in the middle of a scan.

// File: rtl/rws_pkg.sv
package rws_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLR,
    S_WAIT,
    S_CHECK,
    S_STEP,
    S_RET,
    S_WR
  } scan_state_t;

  typedef enum logic [1:0] {
    PH_RIGHT,
    PH_LEFT,
    PH_FINAL
  } phase_t;

  // Phase that follows the completed return walk of a sweep.
  function automatic phase_t next_phase(input phase_t p);
    return (p == PH_RIGHT) ? PH_LEFT : PH_FINAL;
  endfunction

  // True when the sweep in the given direction cannot move further.
  function automatic logic at_tap_limit(input logic up, input int pos, input int top);
    return up ? (pos >= top) : (pos == 0);
  endfunction

endpackage

// File: rtl/rws_settle_timer.sv
module rws_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rws_step_tally.sv
module rws_step_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (up)    count <= count + 1'b1;
    else if (down)  count <= count - 1'b1;
  end
endmodule

// File: rtl/rws_tap_mux.sv
module rws_tap_mux (
  input  logic busy,
  input  logic man_inc,
  input  logic man_dec,
  input  logic scan_inc,
  input  logic scan_dec,
  output logic tap_inc,
  output logic tap_dec
);
  always_comb begin
    if (busy) begin
      tap_inc = scan_inc;
      tap_dec = scan_dec;
    end else begin
      tap_inc = man_inc;
      tap_dec = man_dec;
    end
  end
endmodule

// File: rtl/rws_scanner.sv
module rws_scanner
  import rws_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int TAP_W     = 6,
  parameter int MARGIN_W  = 8,
  parameter int SETTLE_W  = 8,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                man_inc,
  input  logic                man_dec,
  input  logic [TAP_W-1:0]    tap_pos,
  input  logic                err_in,
  output logic                busy,
  output logic                tap_inc,
  output logic                tap_dec,
  output logic                err_clr,
  output logic [LANE_W-1:0]   lane_sel,
  output logic                res_we,
  output logic [LANE_W-1:0]   res_lane,
  output logic [MARGIN_W-1:0] res_left,
  output logic [MARGIN_W-1:0] res_right,
  output logic                res_left_unb,
  output logic                res_right_sat
);
  localparam int TAP_TOP = (1 << TAP_W) - 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  scan_state_t state_q, state_d;
  phase_t      phase_q, phase_d;
  logic        returning_q, returning_d;
  logic [LANE_W-1:0]   lane_q, lane_d;
  logic [MARGIN_W-1:0] steps;
  logic [MARGIN_W-1:0] left_q, right_q;
  logic        lunb_q, rsat_q;

  // Named internal events
  logic dir_up, settle_done, limit_now;
  logic edge_hit, limit_hit, sweep_end;
  logic scan_step, ret_step, ret_done;
  logic scan_inc, scan_dec, timer_load;

  assign dir_up     = (phase_q == PH_RIGHT);
  assign limit_now  = at_tap_limit(dir_up, int'(tap_pos), TAP_TOP);
  assign edge_hit   = (state_q == S_CHECK) && err_in;
  assign limit_hit  = (state_q == S_CHECK) && !err_in && limit_now;
  assign sweep_end  = edge_hit || limit_hit;
  assign scan_step  = (state_q == S_STEP);
  assign ret_step   = (state_q == S_RET) && (steps != '0);
  assign ret_done   = (state_q == S_RET) && (steps == '0);
  assign scan_inc   = (scan_step && dir_up) || (ret_step && !dir_up);
  assign scan_dec   = (scan_step && !dir_up) || (ret_step && dir_up);
  assign timer_load = (state_q == S_CLR) || scan_step || ret_step;

  rws_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (settle_cycles),
    .expired  (settle_done)
  );

  rws_step_tally #(.W(MARGIN_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .clr   (state_q == S_CLR),
    .up    (scan_step),
    .down  (ret_step),
    .count (steps)
  );

  rws_tap_mux u_mux (
    .busy     (busy),
    .man_inc  (man_inc),
    .man_dec  (man_dec),
    .scan_inc (scan_inc),
    .scan_dec (scan_dec),
    .tap_inc  (tap_inc),
    .tap_dec  (tap_dec)
  );

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    returning_d = returning_q;
    lane_d      = lane_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d     = S_CLR;
        phase_d     = PH_RIGHT;
        returning_d = 1'b0;
        lane_d      = '0;
      end
      S_CLR:  state_d = S_WAIT;
      S_WAIT: if (settle_done) begin
        if (returning_q)              state_d = S_RET;
        else if (phase_q == PH_FINAL) state_d = S_WR;
        else                          state_d = S_CHECK;
      end
      S_CHECK: if (sweep_end) begin
        state_d     = S_RET;
        returning_d = 1'b1;
      end else begin
        state_d = S_STEP;
      end
      S_STEP: state_d = S_WAIT;
      S_RET: if (ret_done) begin
        state_d     = S_CLR;
        returning_d = 1'b0;
        phase_d     = next_phase(phase_q);
      end else begin
        state_d = S_WAIT;
      end
      S_WR: if (lane_q == LAST_LANE) begin
        state_d = S_IDLE;
      end else begin
        state_d = S_CLR;
        lane_d  = lane_q + 1'b1;
        phase_d = PH_RIGHT;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      phase_q     <= PH_RIGHT;
      returning_q <= 1'b0;
      lane_q      <= '0;
    end else begin
      state_q     <= state_d;
      phase_q     <= phase_d;
      returning_q <= returning_d;
      lane_q      <= lane_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
      lunb_q  <= 1'b0;
      rsat_q  <= 1'b0;
    end else if (sweep_end) begin
      if (dir_up) begin
        right_q <= steps;
        rsat_q  <= limit_hit;
      end else begin
        left_q  <= steps;
        lunb_q  <= limit_hit;
      end
    end
  end

  assign busy          = (state_q != S_IDLE) || start;
  assign err_clr       = (state_q == S_CLR);
  assign lane_sel      = lane_q;
  assign res_we        = (state_q == S_WR);
  assign res_lane      = lane_q;
  assign res_left      = left_q;
  assign res_right     = right_q;
  assign res_left_unb  = lunb_q;
  assign res_right_sat = rsat_q;
endmodule

// File: rtl/rws_scanner_chk.sv
module rws_scanner_chk #(
  parameter int NUM_LANES = 8,
  parameter int SETTLE_W  = 8,
  parameter int LANE_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                tap_inc,
  input logic                tap_dec,
  input logic                err_clr,
  input logic                res_we,
  input logic [LANE_W-1:0]   res_lane,
  input logic [LANE_W-1:0]   lane_sel,
  input logic [SETTLE_W-1:0] settle_cycles
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  // Cycles since the last scanner action, saturating.
  logic [SETTLE_W:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || !busy || tap_inc || tap_dec || err_clr) gap_q <= '0;
    else if (gap_q != '1)                              gap_q <= gap_q + 1'b1;
  end

  assert_busy_drop_R1: assert property (@(posedge clk) disable iff (rst)
    (res_we && res_lane == LAST_LANE) |=> (!busy || start));

  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> $onehot0({tap_inc, tap_dec, err_clr}));

  assert_lane_order_R6: assert property (@(posedge clk) disable iff (rst)
    (res_we && res_lane != LAST_LANE) |=> (lane_sel == LANE_W'($past(res_lane) + 1'b1)));

  assert_settle_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (tap_inc || tap_dec)) |-> (gap_q >= {1'b0, settle_cycles}));

  assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
    res_we |=> !res_we);

  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (!res_we && !err_clr));
endmodule

bind rws_scanner rws_scanner_chk #(
  .NUM_LANES (NUM_LANES),
  .SETTLE_W  (SETTLE_W),
  .LANE_W    (LANE_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .tap_inc       (tap_inc),
  .tap_dec       (tap_dec),
  .err_clr       (err_clr),
  .res_we        (res_we),
  .res_lane      (res_lane),
  .lane_sel      (lane_sel),
  .settle_cycles (settle_cycles)
);

// File: tb/rws_scanner_tb.sv
module rws_scanner_tb;
  localparam int NL = 4;
  localparam int NV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] settle_cycles = 8'd4;
  logic       man_inc = 1'b0, man_dec = 1'b0;
  logic [5:0] tap_pos;
  logic       err_in;
  logic       busy, tap_inc, tap_dec, err_clr, res_we;
  logic [1:0] lane_sel, res_lane;
  logic [7:0] res_left, res_right;
  logic       res_left_unb, res_right_sat;

  always #2.5 clk = ~clk;

  rws_scanner #(.NUM_LANES(NL), .TAP_W(6), .MARGIN_W(8), .SETTLE_W(8)) u_dut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
    .man_inc(man_inc), .man_dec(man_dec), .tap_pos(tap_pos), .err_in(err_in),
    .busy(busy), .tap_inc(tap_inc), .tap_dec(tap_dec), .err_clr(err_clr),
    .lane_sel(lane_sel), .res_we(res_we), .res_lane(res_lane),
    .res_left(res_left), .res_right(res_right),
    .res_left_unb(res_left_unb), .res_right_sat(res_right_sat)
  );

  // Stimulus table: per vector, per lane calibrated tap, left and right window widths.
  localparam int T_CAL [NV][NL] = '{'{30, 20, 40, 10}, '{2, 0, 5, 1},
                                    '{60, 63, 50, 55}, '{32, 32, 32, 32}};
  localparam int T_LW  [NV][NL] = '{'{5, 3, 8, 2},     '{5, 1, 10, 1},
                                    '{2, 2, 2, 2},     '{0, 0, 0, 0}};
  localparam int T_RW  [NV][NL] = '{'{6, 4, 2, 9},     '{3, 3, 3, 3},
                                    '{5, 0, 20, 7},    '{0, 0, 0, 0}};
  localparam int T_SET [NV]     = '{4, 3, 5, 2};

  // Delay line and traffic checker model
  int   cal_cfg [NL];
  int   lw_cfg  [NL];
  int   rw_cfg  [NL];
  int   taps    [NL];
  logic preset_req = 1'b0;
  logic err_q = 1'b0;

  assign tap_pos = 6'(taps[lane_sel]);
  assign err_in  = err_q;

  always @(posedge clk) begin
    if (preset_req) begin
      for (int i = 0; i < NL; i++) taps[i] <= cal_cfg[i];
    end else begin
      if (tap_inc && taps[lane_sel] < 63) taps[lane_sel] <= taps[lane_sel] + 1;
      if (tap_dec && taps[lane_sel] > 0)  taps[lane_sel] <= taps[lane_sel] - 1;
    end
    if (err_clr) err_q <= 1'b0;
    else if (taps[lane_sel] > cal_cfg[lane_sel] + rw_cfg[lane_sel] ||
             taps[lane_sel] < cal_cfg[lane_sel] - lw_cfg[lane_sel]) err_q <= 1'b1;
  end

  // Result collector and strobe-gap monitor
  int got_left [NL], got_right [NL], got_cnt [NL];
  bit got_lunb [NL], got_rsat [NL];
  int writes = 0, cyc = 0, last_act = -1, min_gap = 1000;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start) begin
      min_gap  <= 1000;
      last_act <= -1;
      for (int i = 0; i < NL; i++) got_cnt[i] <= 0;
    end else if (busy && (tap_inc || tap_dec)) begin
      if (last_act >= 0 && cyc - last_act < min_gap) min_gap <= cyc - last_act;
      last_act <= cyc;
    end else if (busy && err_clr) begin
      last_act <= cyc;
    end
    if (res_we) begin
      writes                <= writes + 1;
      got_left[res_lane]    <= int'(res_left);
      got_right[res_lane]   <= int'(res_right);
      got_lunb[res_lane]    <= res_left_unb;
      got_rsat[res_lane]    <= res_right_sat;
      got_cnt[res_lane]     <= got_cnt[res_lane] + 1;
    end
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_right(input int cal, input int rw);
    return (rw + 1 <= 63 - cal) ? rw + 1 : 63 - cal;
  endfunction
  function automatic bit exp_rsat(input int cal, input int rw);
    return !(rw + 1 <= 63 - cal);
  endfunction
  function automatic int exp_left(input int cal, input int lw);
    return (lw + 1 <= cal) ? lw + 1 : cal;
  endfunction
  function automatic bit exp_lunb(input int cal, input int lw);
    return !(lw + 1 <= cal);
  endfunction

  task automatic preset_taps();
    @(negedge clk) preset_req = 1'b1;
    @(negedge clk) preset_req = 1'b0;
  endtask

  task automatic run_scan(input int settle, input bit noise);
    int w0;
    preset_taps();
    settle_cycles = 8'(settle);
    w0 = writes;
    @(negedge clk);
    start = 1'b1;
    #1 chk(busy == 1'b1, "R1 busy in start cycle", int'(busy), 1);
    @(negedge clk);
    start = 1'b0;
    if (noise) man_inc = 1'b1;
    while (!(res_we && res_lane == 2'(NL - 1))) begin
      @(negedge clk);
      if (noise) man_dec = ~man_dec;
    end
    man_inc = 1'b0;
    man_dec = 1'b0;
    chk(busy == 1'b1, "R1 busy during last write", int'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy low after last write", int'(busy), 0);
    chk(writes - w0 == NL, "R11 one write per lane", writes - w0, NL);
    chk(min_gap >= settle, "R9 settle gap", min_gap, settle);
    for (int l = 0; l < NL; l++) begin
      chk(got_cnt[l] == 1, "R6 lane written once", got_cnt[l], 1);
      chk(got_right[l] == exp_right(cal_cfg[l], rw_cfg[l]), "R3 right margin",
          got_right[l], exp_right(cal_cfg[l], rw_cfg[l]));
      chk(got_left[l] == exp_left(cal_cfg[l], lw_cfg[l]), "R5 left margin",
          got_left[l], exp_left(cal_cfg[l], lw_cfg[l]));
      chk(got_rsat[l] == exp_rsat(cal_cfg[l], rw_cfg[l]), "R8 right saturated flag",
          int'(got_rsat[l]), int'(exp_rsat(cal_cfg[l], rw_cfg[l])));
      chk(got_lunb[l] == exp_lunb(cal_cfg[l], lw_cfg[l]), "R7 left unbounded flag",
          int'(got_lunb[l]), int'(exp_lunb(cal_cfg[l], lw_cfg[l])));
      chk(taps[l] == cal_cfg[l], noise ? "R2 manual ignored, tap restored" : "R10 tap restored",
          taps[l], cal_cfg[l]);
    end
  endtask

  task automatic load_vec(input int v);
    for (int l = 0; l < NL; l++) begin
      cal_cfg[l] = T_CAL[v][l];
      lw_cfg[l]  = T_LW[v][l];
      rw_cfg[l]  = T_RW[v][l];
    end
  endtask

  initial begin
    int w1;
    load_vec(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    #1;
    chk(busy == 1'b0 && res_we == 1'b0, "R12 idle after reset", int'(busy), 0);
    chk(tap_inc == 1'b0 && tap_dec == 1'b0 && err_clr == 1'b0, "R12 no strobes after reset",
        int'({tap_inc, tap_dec, err_clr}), 0);

    // Table walk (R4 is also covered: each sweep depends on a return and a clear)
    for (int v = 0; v < NV; v++) begin
      load_vec(v);
      run_scan(T_SET[v], v == 1);
    end

    // Default settle of 16 on vector 0
    load_vec(0);
    run_scan(16, 1'b0);

    // R2 idle pass-through
    @(negedge clk);
    man_inc = 1'b1;
    #1 chk(tap_inc == 1'b1 && tap_dec == 1'b0, "R2 idle inc pass-through", int'(tap_inc), 1);
    @(negedge clk);
    man_inc = 1'b0;
    man_dec = 1'b1;
    #1 chk(tap_dec == 1'b1 && tap_inc == 1'b0, "R2 idle dec pass-through", int'(tap_dec), 1);
    @(negedge clk);
    man_dec = 1'b0;

    // R12 reset in mid-scan
    preset_taps();
    settle_cycles = 8'd4;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1;
    chk(busy == 1'b0, "R12 busy cleared by reset", int'(busy), 0);
    chk(tap_inc == 1'b0 && tap_dec == 1'b0 && err_clr == 1'b0 && res_we == 1'b0,
        "R12 outputs quiet after reset", int'({tap_inc, tap_dec, err_clr, res_we}), 0);
    w1 = writes;
    repeat (100) @(negedge clk);
    chk(writes == w1, "R12 no result after abort", writes - w1, 0);
    chk(busy == 1'b0, "R12 stays idle after abort", int'(busy), 0);

    // Scan still works after the abort
    load_vec(3);
    run_scan(3, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule